// File: doc/BRIEF.md
# Paced Transfer Valid-Phase Encoder

This block sits on the transmit side of a paced double-transition data phase. The transfer clock runs freely, and every REQ/ACK edge marks one transfer period. The upstream data path presents a per-period request saying whether it has data to send. The block turns that request into the waveform of a single qualifier line, P1. The receiver does not read P1 as a level. It reads the phase of the line's toggling.

Periods are grouped in pairs, because valid data always moves in four-byte units. At the first period of each pair, P1 normally toggles. To switch between the valid and invalid states, the block withholds that toggle, which leaves P1 flat for two periods and reverses its phase. Each state has a minimum length. A valid run is at least one pair. An invalid run is at least two pairs and always contains one toggle. A request for valid data that comes too early is held off. The data-accepted output shows which periods actually carry valid data.

Top module: `paced_p1_encoder`

## Requirements
- R1: After reset, `p1` is 0 and `data_accepted` is 0.
- R2: `p1` changes only in the clock cycle that follows a `period_stb` pulse. It never changes at the second period of a pair.
- R3: While the state stays the same, whether valid or invalid, `p1` toggles at the first period of every pair.
- R4: When the block enters the valid state at a pair start, `p1` does not toggle there. `data_accepted` is 1 for both periods of that pair.
- R5: When `data_valid` is 0 at a pair start during the valid state, `p1` withholds its toggle and `data_accepted` goes to 0.
- R6: An invalid run lasts at least four periods. A `data_valid` request that arrives earlier is held off, and `data_accepted` stays 0.
- R7: `data_valid` is sampled only at the first period of a pair. Its value at the second period has no effect.
- R8: While `paced_en` is 0, strobes are ignored, `p1` holds its value and `data_accepted` is 0. The invalid minimum restarts when the block is enabled again.
- R9: After reset or enable, the first valid period is no earlier than the fifth strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| paced_en | input | 1 | Paced mode enable |
| period_stb | input | 1 | One-cycle pulse at the start of each transfer period |
| data_valid | input | 1 | Upstream request: data is available for this period |
| p1 | output | 1 | Phase-coded valid qualifier line |
| data_accepted | output | 1 | High during periods that carry valid data |

## Verification
The bench raises a valid request at the second period of a pair, both while the block is valid and while it is invalid. A design that samples the request every period would switch state in the middle of a pair and toggle P1 at the wrong edge. The bench also requests valid data right after a pause and right after enable. A design that ignores the four-period minimum would accept data too early and skip the toggle that the invalid run requires. Strobes given while the block is disabled must leave P1 frozen. A long random run then checks that the phase bookkeeping never drifts.

// File: rtl/paced_p1_encoder.sv
module paced_p1_encoder #(
  parameter int MIN_INV_PAIRS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic paced_en,
  input  logic period_stb,
  input  logic data_valid,
  output logic p1,
  output logic data_accepted
);
  localparam int CW = $clog2(MIN_INV_PAIRS + 1);
  localparam int MIN_INV_PERIODS = 2 * MIN_INV_PAIRS;

  logic          second_q;
  logic          valid_q;
  logic          p1_q;
  logic [CW-1:0] inv_q;

  wire may_valid = (inv_q == CW'(MIN_INV_PAIRS));
  wire go_valid  = ~valid_q & data_valid & may_valid;
  wire go_inv    = valid_q & ~data_valid;
  wire flip      = go_valid | go_inv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      second_q <= 1'b1;
      valid_q  <= 1'b0;
      p1_q     <= 1'b0;
      inv_q    <= '0;
    end else if (!paced_en) begin
      second_q <= 1'b1;
      valid_q  <= 1'b0;
      inv_q    <= '0;
    end else if (period_stb) begin
      second_q <= ~second_q;
      if (second_q) begin
        valid_q <= valid_q ^ flip;
        p1_q    <= flip ? p1_q : ~p1_q;
        if (go_inv)
          inv_q <= CW'(1);
        else if (go_valid)
          inv_q <= '0;
        else if (!valid_q && !may_valid)
          inv_q <= inv_q + CW'(1);
      end
    end
  end

  assign p1            = p1_q;
  assign data_accepted = valid_q;

  logic [3:0] ck_inv;
  always_ff @(posedge clk) begin
    if (!rst_n || !paced_en)
      ck_inv <= '0;
    else if (period_stb)
      ck_inv <= data_accepted ? 4'd0 : ((ck_inv == 4'hf) ? ck_inv : ck_inv + 4'd1);
  end

  p_no_toggle_without_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !period_stb |=> $stable(p1));
  p_no_mid_pair_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (period_stb && paced_en && !second_q) |=> $stable(p1));
  p_enter_valid_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_accepted) |-> $stable(p1));
  p_leave_valid_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_accepted) |-> $stable(p1));
  p_invalid_minimum_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_accepted) |-> (ck_inv >= 4'(MIN_INV_PERIODS)));
  p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !paced_en |=> (!data_accepted && $stable(p1)));
endmodule

// File: tb/paced_p1_encoder_tb_top.sv
module paced_p1_encoder_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic paced_en = 1'b0;
  logic period_stb = 1'b0;
  logic data_valid = 1'b0;
  logic p1, data_accepted;

  always #(CLK_PERIOD/2) clk = ~clk;

  paced_p1_encoder dut_i (
    .clk(clk), .rst_n(rst_n), .paced_en(paced_en), .period_stb(period_stb),
    .data_valid(data_valid), .p1(p1), .data_accepted(data_accepted)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [1:0] exp_q[$];
  string tag_q[$];

  bit m_p1 = 0, m_valid = 0, m_second = 1, m_fresh = 1;
  int m_invp = 0;

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {p1,acc} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_valid = 0; m_second = 1; m_invp = 0; m_fresh = 1;
  endtask

  task automatic period(input bit dv);
    string tag;
    @(negedge clk);
    period_stb = 1'b1;
    data_valid = dv;
    if (!paced_en) begin
      tag = "R8";
    end else if (!m_second) begin
      tag = "R7";
      m_second = 1;
      if (!m_valid) m_invp++;
    end else begin
      m_second = 0;
      if (m_valid && !dv) begin
        m_valid = 0; m_invp = 1; tag = "R5";
      end else if (!m_valid && dv && m_invp >= 4) begin
        m_valid = 1; m_fresh = 0; tag = "R4";
      end else begin
        m_p1 = ~m_p1;
        if (!m_valid) begin
          if (dv) tag = m_fresh ? "R9" : "R6";
          else tag = "R3";
          m_invp++;
        end else tag = "R3";
      end
    end
    exp_q.push_back({m_p1, m_valid});
    tag_q.push_back(tag);
    @(negedge clk);
    period_stb = 1'b0;
    data_valid = 1'b0;
    @(negedge clk);
  endtask

  logic seen = 1'b0;
  always @(posedge clk) seen <= period_stb;

  always @(negedge clk) begin
    if (seen && exp_q.size() > 0)
      check(tag_q.pop_front(), {p1, data_accepted}, exp_q.pop_front());
  end

  bit done = 0;
  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {p1, data_accepted}, 2'b00);
    paced_en = 1'b1;
    @(negedge clk);
    repeat (4) period(1);
    repeat (4) period(1);
    period(0);
    period(1);
    repeat (3) period(1);
    period(0);
    repeat (6) period(0);
    repeat (6) period(1);
    repeat (6) @(negedge clk);
    check("R2", {p1, data_accepted}, {m_p1, m_valid});
    @(negedge clk);
    paced_en = 1'b0;
    model_reset();
    @(negedge clk);
    check("R8", {p1, data_accepted}, {m_p1, 1'b0});
    repeat (3) period(1);
    @(negedge clk);
    paced_en = 1'b1;
    @(negedge clk);
    repeat (8) period(1);
    for (int i = 0; i < 80; i++) period(1'($urandom_range(0, 1)));
    repeat (4) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule